// File: doc/BRIEF.md
# Byte-Port Packet Mailbox

This peripheral passes whole network frames between a host processor and a byte-stream network port. The host sees a small 32-bit register window. To send a frame, it writes the frame length into a transmit length register and then pushes the frame one byte per write through a transmit data port. To receive, it learns the length of a waiting frame from a receive count register and pops the frame one byte per read from a receive data port. That count falls by one on every pop.

Each direction owns one frame buffer. On the receive side, capture closes after a complete frame. Nothing more is accepted until the host acknowledges the receive interrupt; until then the stream input is held off through its ready signal. On the transmit side, the frame goes out on the stream output as soon as its final byte has been written. A transmit-done flag is raised after the frame has gone out. A self-test bit lets software raise the interrupt line without traffic, so it can check its handler.

Top module: `pktmbox`

## Requirements
- R1: Word 0x00 reads 0x4D544B50 and word 0x04 reads 0x31584F42. Together these are the ASCII identifier "PKTMBOX" followed by the version digit (default 1), with byte 0 in bits 7:0 of word 0x00. Word 0x18 reads the constant parameter IRQ_INFO (default 2).
- R2: After reset, every register reads 0 except the identifier and info words. The irq output is 0, rx_ready is 1 and tx_valid is 0.
- R3: When a stream frame completes (the beat with rx_last accepted), the receive count at 0x0C holds the number of bytes captured. Bit 1 of the interrupt register at 0x14 becomes 1.
- R4: Each read of 0x1C while the receive count is non-zero returns the next frame byte in bits 7:0, with zeros above, and decrements the count by one. A read of 0x1C with a count of 0 returns 0 and leaves the count at 0.
- R5: While bit 1 of 0x14 is set, rx_ready is 0, so no stream beat is taken. rx_ready returns to 1 once that bit is cleared.
- R6: A received frame longer than DEPTH bytes (default 64) keeps its first DEPTH bytes and reports a count of DEPTH.
- R7: A write to 0x10 starts a transmit whose length is the written value clamped to DEPTH. While that transmit is pending, 0x10 reads the length, and a further write to 0x10 has no effect. 0x10 reads 0 once the final byte has been written. Writes to 0x20 use only bits 7:0, and they are ignored when no transmit is awaiting data.
- R8: After the final byte write, the frame leaves on tx_valid/tx_data in consecutive cycles, in the order written, with tx_last on the final byte only. Bit 0 of 0x14 is then set.
- R9: A write to 0x14 clears each of bits 0 and 1 for which the written bit is 1. It leaves a bit alone when the written bit is 0.
- R10: Writing bit 31 of 0x14 as 1 raises irq and sets status bit 31. The first read of 0x14 after that returns bit 31 as 1 and clears it, while irq stays high. A write of exactly 0 to 0x14 releases that test request.
- R11: Register 0x08 reads 1 while a received frame is partly captured or a transmit is awaiting data or being emitted. Otherwise it reads 0.
- R12: irq is 1 exactly when bit 0 or bit 1 of 0x14 is set or a test request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Register access this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Byte address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for the addressed register, combinational |
| rx_valid | input | 1 | Receive stream byte valid |
| rx_data | input | 8 | Receive stream byte |
| rx_last | input | 1 | Final byte of the receive frame |
| rx_ready | output | 1 | Receive stream byte accepted when high with rx_valid |
| tx_valid | output | 1 | Transmit stream byte valid |
| tx_data | output | 8 | Transmit stream byte |
| tx_last | output | 1 | Final byte of the transmit frame |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a stream frame arriving while the previous frame is still unacknowledged. To force it, the bench completes a frame, leaves bit 1 of the interrupt register set, and holds a valid byte on the stream for several cycles. It checks that rx_ready stays low and the count does not move. It then acknowledges and sends again. Overlong frames in both directions are forced by directed lengths above the buffer depth. A partly captured frame is held open by stopping the stream before its last beat, so the busy register can be read mid-frame. Random frame lengths and contents drive the remaining traffic.

// File: rtl/pktmbox_pkg.sv
package pktmbox_pkg;

   typedef enum logic [5:0] {
      A_ID_LO  = 6'h00,
      A_ID_HI  = 6'h04,
      A_BUSY   = 6'h08,
      A_RXCNT  = 6'h0C,
      A_TXCNT  = 6'h10,
      A_INTCTL = 6'h14,
      A_INFO   = 6'h18,
      A_RXDAT  = 6'h1C,
      A_TXDAT  = 6'h20
   } reg_addr_e;

   localparam int unsigned BIT_TXDONE = 0;
   localparam int unsigned BIT_RXRDY  = 1;
   localparam int unsigned BIT_TEST   = 31;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_FILL,
      TX_SEND
   } tx_phase_e;

endpackage

// File: rtl/pktmbox_rxbuf.sv
module pktmbox_rxbuf #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_valid,
   input  logic [7:0]       s_data,
   input  logic             s_last,
   output logic             s_ready,
   input  logic             lock,
   input  logic             pop,
   output logic [7:0]       pop_data,
   output logic [CNT_W-1:0] count,
   output logic             capturing,
   output logic             frame_done
);
   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned PTR_W = IDX_W + 1;

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wr_idx;
   logic [PTR_W-1:0] rd_idx;
   logic             accept;
   logic             room;

   assign s_ready    = !lock;
   assign accept     = s_valid && s_ready;
   assign room       = wr_idx < PTR_W'(DEPTH);
   assign frame_done = accept && s_last;
   assign pop_data   = (count != '0) ? mem[rd_idx[IDX_W-1:0]] : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= 8'h00;
      end else if (accept && room) begin
         mem[wr_idx[IDX_W-1:0]] <= s_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx    <= '0;
         capturing <= 1'b0;
      end else if (accept) begin
         capturing <= !s_last;
         if (s_last)    wr_idx <= '0;
         else if (room) wr_idx <= wr_idx + PTR_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         rd_idx <= '0;
      end else if (frame_done) begin
         count  <= room ? CNT_W'(wr_idx) + CNT_W'(1) : CNT_W'(DEPTH);
         rd_idx <= '0;
      end else if (pop && count != '0) begin
         count  <= count - CNT_W'(1);
         rd_idx <= rd_idx + PTR_W'(1);
      end
   end

endmodule

// File: rtl/pktmbox_txbuf.sv
module pktmbox_txbuf
   import pktmbox_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_we,
   input  logic [31:0]      len_in,
   input  logic             data_we,
   input  logic [7:0]       data_in,
   output logic [CNT_W-1:0] count,
   output logic             active,
   output logic             m_valid,
   output logic [7:0]       m_data,
   output logic             m_last,
   output logic             done
);
   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned PTR_W = IDX_W + 1;

   tx_phase_e        phase;
   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] len;
   logic [PTR_W-1:0] idx;
   logic [PTR_W-1:0] clamped;
   logic             at_end;

   assign clamped = (len_in > 32'(DEPTH)) ? PTR_W'(DEPTH) : PTR_W'(len_in);
   assign at_end  = (idx + PTR_W'(1)) == len;
   assign active  = phase != TX_IDLE;
   assign m_valid = phase == TX_SEND;
   assign m_data  = m_valid ? mem[idx[IDX_W-1:0]] : 8'h00;
   assign m_last  = m_valid && at_end;
   assign done    = m_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= 8'h00;
      end else if (data_we && phase == TX_FILL) begin
         mem[idx[IDX_W-1:0]] <= data_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= TX_IDLE;
         len   <= '0;
         idx   <= '0;
         count <= '0;
      end else begin
         unique case (phase)
            TX_IDLE: if (len_we && clamped != '0) begin
               len   <= clamped;
               count <= CNT_W'(clamped);
               idx   <= '0;
               phase <= TX_FILL;
            end
            TX_FILL: if (data_we) begin
               if (at_end) begin
                  idx   <= '0;
                  count <= '0;
                  phase <= TX_SEND;
               end else begin
                  idx <= idx + PTR_W'(1);
               end
            end
            TX_SEND: begin
               if (at_end) phase <= TX_IDLE;
               idx <= at_end ? '0 : idx + PTR_W'(1);
            end
            default: phase <= TX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pktmbox_irq.sv
module pktmbox_irq
   import pktmbox_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tx_done_set,
   input  logic        rx_done_set,
   input  logic        wr_ctl,
   input  logic        rd_ctl,
   input  logic [31:0] wdata,
   output logic [31:0] status,
   output logic        rx_lock,
   output logic        irq
);
   logic tx_flag;
   logic rx_flag;
   logic test_flag;
   logic test_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_flag   <= 1'b0;
         rx_flag   <= 1'b0;
         test_flag <= 1'b0;
         test_hold <= 1'b0;
      end else begin
         if (tx_done_set)                          tx_flag <= 1'b1;
         else if (wr_ctl && wdata[BIT_TXDONE])     tx_flag <= 1'b0;
         if (rx_done_set)                          rx_flag <= 1'b1;
         else if (wr_ctl && wdata[BIT_RXRDY])      rx_flag <= 1'b0;
         if (wr_ctl && wdata[BIT_TEST])            test_flag <= 1'b1;
         else if (rd_ctl)                          test_flag <= 1'b0;
         if (wr_ctl && wdata[BIT_TEST])            test_hold <= 1'b1;
         else if (wr_ctl && wdata == 32'h0)        test_hold <= 1'b0;
      end
   end

   always_comb begin
      status             = '0;
      status[BIT_TXDONE] = tx_flag;
      status[BIT_RXRDY]  = rx_flag;
      status[BIT_TEST]   = test_flag;
   end

   assign rx_lock = rx_flag;
   assign irq     = tx_flag || rx_flag || test_hold;

endmodule

// File: rtl/pktmbox.sv
module pktmbox
   import pktmbox_pkg::*;
#(
   parameter int unsigned DEPTH    = 64,
   parameter int unsigned MAX_LEN  = 65536,
   parameter int unsigned ID_VER   = 1,
   parameter logic [31:0] IRQ_INFO = 32'h2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_sel,
   input  logic        host_wr,
   input  logic [5:0]  host_addr,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   input  logic        rx_valid,
   input  logic [7:0]  rx_data,
   input  logic        rx_last,
   output logic        rx_ready,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        tx_last,
   output logic        irq
);
   localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH > MAX_LEN) begin : g_bad_depth
      $error("pktmbox: DEPTH must be a power of two between 2 and MAX_LEN");
   end
   if (ID_VER > 9) begin : g_bad_ver
      $error("pktmbox: ID_VER must be a single decimal digit");
   end

   function automatic logic [7:0] id_char(input int unsigned k);
      case (k)
         0: return "P";
         1: return "K";
         2: return "T";
         3: return "M";
         4: return "B";
         5: return "O";
         6: return "X";
         default: return 8'(8'h30 + ID_VER);
      endcase
   endfunction

   logic [63:0] id_word;
   for (genvar g = 0; g < 8; g++) begin : g_id
      assign id_word[8*g +: 8] = id_char(g);
   end

   logic             rd_en, wr_en;
   logic [CNT_W-1:0] rx_cnt, tx_cnt;
   logic [7:0]       rx_byte;
   logic             rx_capturing, rx_frame_done, rx_lock;
   logic             tx_active, tx_done;
   logic [31:0]      int_status;

   assign rd_en = host_sel && !host_wr;
   assign wr_en = host_sel && host_wr;

   pktmbox_rxbuf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_rxbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .s_valid    (rx_valid),
      .s_data     (rx_data),
      .s_last     (rx_last),
      .s_ready    (rx_ready),
      .lock       (rx_lock),
      .pop        (rd_en && host_addr == A_RXDAT),
      .pop_data   (rx_byte),
      .count      (rx_cnt),
      .capturing  (rx_capturing),
      .frame_done (rx_frame_done)
   );

   pktmbox_txbuf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_txbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .len_we  (wr_en && host_addr == A_TXCNT),
      .len_in  (host_wdata),
      .data_we (wr_en && host_addr == A_TXDAT),
      .data_in (host_wdata[7:0]),
      .count   (tx_cnt),
      .active  (tx_active),
      .m_valid (tx_valid),
      .m_data  (tx_data),
      .m_last  (tx_last),
      .done    (tx_done)
   );

   pktmbox_irq i_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_done_set (tx_done),
      .rx_done_set (rx_frame_done),
      .wr_ctl      (wr_en && host_addr == A_INTCTL),
      .rd_ctl      (rd_en && host_addr == A_INTCTL),
      .wdata       (host_wdata),
      .status      (int_status),
      .rx_lock     (rx_lock),
      .irq         (irq)
   );

   always_comb begin
      case (host_addr)
         A_ID_LO:  host_rdata = id_word[31:0];
         A_ID_HI:  host_rdata = id_word[63:32];
         A_BUSY:   host_rdata = {31'b0, rx_capturing || tx_active};
         A_RXCNT:  host_rdata = 32'(rx_cnt);
         A_TXCNT:  host_rdata = 32'(tx_cnt);
         A_INTCTL: host_rdata = int_status;
         A_INFO:   host_rdata = IRQ_INFO;
         A_RXDAT:  host_rdata = {24'b0, rx_byte};
         default:  host_rdata = 32'h0;
      endcase
   end

endmodule

// File: rtl/pktmbox_chk.sv
module pktmbox_chk #(
   parameter int unsigned CNT_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_sel,
   input logic             host_wr,
   input logic [5:0]       host_addr,
   input logic [31:0]      host_wdata,
   input logic             rx_valid,
   input logic             rx_ready,
   input logic             rx_last,
   input logic             tx_valid,
   input logic             tx_last,
   input logic             irq,
   input logic [CNT_W-1:0] rx_cnt
);
   logic rx_end;
   logic pop_rd;
   assign rx_end = rx_valid && rx_ready && rx_last;
   assign pop_rd = host_sel && !host_wr && host_addr == 6'h1C;

   a_r8_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   a_r8_burst_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_last |=> tx_valid);

   a_r8_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_last |=> irq);

   a_r5_locked_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      rx_end |=> !rx_ready && irq);

   a_r4_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
      pop_rd && rx_cnt != '0 && !rx_end |=> rx_cnt == $past(rx_cnt) - CNT_W'(1));

   a_r4_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt == '0 && !rx_end |=> rx_cnt == '0);

   a_r10_test_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      host_sel && host_wr && host_addr == 6'h14 && host_wdata[31] |=> irq);

endmodule

bind pktmbox pktmbox_chk #(.CNT_W(CNT_W)) i_pktmbox_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_sel   (host_sel),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .rx_valid   (rx_valid),
   .rx_ready   (rx_ready),
   .rx_last    (rx_last),
   .tx_valid   (tx_valid),
   .tx_last    (tx_last),
   .irq        (irq),
   .rx_cnt     (rx_cnt)
);

// File: tb/test_pktmbox.sv
`timescale 1ns/1ps
module test_pktmbox;
   localparam int DEPTH = 64;
   localparam logic [5:0] A_IDL = 6'h00, A_IDH = 6'h04, A_BSY = 6'h08, A_RXC = 6'h0C,
                          A_TXC = 6'h10, A_INT = 6'h14, A_INF = 6'h18, A_RXD = 6'h1C,
                          A_TXD = 6'h20;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        host_sel = 1'b0, host_wr = 1'b0;
   logic [5:0]  host_addr = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
   logic [7:0]  rx_data = '0, tx_data;
   logic        tx_valid, tx_last, irq;

   int n_checks = 0, n_errs = 0;
   logic [7:0] rx_bytes [DEPTH+16];
   logic [7:0] tx_bytes [DEPTH];
   logic [7:0] tx_q [$];
   int last_pos = 0;
   logic [31:0] rv;

   always #4 clk = ~clk;

   pktmbox #(.DEPTH(DEPTH)) i_pktmbox (.*);

   always @(negedge clk) if (tx_valid) begin
      tx_q.push_back(tx_data);
      if (tx_last) last_pos = tx_q.size();
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk); host_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
      #1 d = host_rdata;
      @(negedge clk); host_sel = 1'b0;
   endtask

   task automatic rx_beat(input logic [7:0] b, input logic last);
      @(negedge clk); rx_valid = 1'b1; rx_data = b; rx_last = last;
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
   endtask

   task automatic rx_send(input int n);
      for (int i = 0; i < n; i++) rx_beat(rx_bytes[i], i == n - 1);
      @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   task automatic rx_check(input int n);
      int e;
      e = (n > DEPTH) ? DEPTH : n;
      host_read(A_RXC, rv);  check(n > DEPTH ? "R6 clipped count" : "R3 rx count", rv, 32'(e));
      host_read(A_INT, rv);  check("R3 rx flag", rv, 32'h2);
      check("R12 irq on rx", 32'(irq), 32'h1);
      for (int i = 0; i < e; i++) begin
         host_read(A_RXD, rv); check("R4 rx byte", rv, {24'h0, rx_bytes[i]});
         if (i == 0) begin host_read(A_RXC, rv); check("R4 count after pop", rv, 32'(e - 1)); end
      end
      host_read(A_RXD, rv);  check("R4 empty read", rv, 32'h0);
      host_read(A_RXC, rv);  check("R4 count stays 0", rv, 32'h0);
      host_write(A_INT, 32'h2);
      host_read(A_INT, rv);  check("R9 ack rx", rv, 32'h0);
      check("R5 ready after ack", 32'(rx_ready), 32'h1);
   endtask

   task automatic tx_run(input int n);
      int e, bad;
      e = (n > DEPTH) ? DEPTH : n;
      for (int i = 0; i < e; i++) tx_bytes[i] = 8'($urandom);
      tx_q.delete(); last_pos = 0;
      host_write(A_TXC, 32'(n));
      host_read(A_TXC, rv);  check("R7 tx length", rv, 32'(e));
      host_read(A_BSY, rv);  check("R11 busy tx", rv, 32'h1);
      host_write(A_TXC, 32'h5);
      host_read(A_TXC, rv);  check("R7 rewrite ignored", rv, 32'(e));
      for (int i = 0; i < e; i++) host_write(A_TXD, {24'($urandom), tx_bytes[i]});
      host_read(A_TXC, rv);  check("R7 cleared", rv, 32'h0);
      repeat (e + 3) @(negedge clk);
      check("R8 byte total", 32'(tx_q.size()), 32'(e));
      bad = 0;
      for (int i = 0; i < e && i < tx_q.size(); i++) if (tx_q[i] !== tx_bytes[i]) bad++;
      check("R8 byte mismatches", 32'(bad), 32'h0);
      check("R8 last position", 32'(last_pos), 32'(e));
      host_read(A_INT, rv);  check("R8 tx done", rv, 32'h1);
      check("R12 irq on tx", 32'(irq), 32'h1);
      host_read(A_BSY, rv);  check("R11 idle", rv, 32'h0);
      host_write(A_INT, 32'h1);
      host_read(A_INT, rv);  check("R9 ack tx", rv, 32'h0);
      check("R12 irq low", 32'(irq), 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin
      rv = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2 reset state
      check("R2 irq", 32'(irq), 32'h0);
      check("R2 rx_ready", 32'(rx_ready), 32'h1);
      check("R2 tx_valid", 32'(tx_valid), 32'h0);
      host_read(A_BSY, rv); check("R2 busy", rv, 32'h0);
      host_read(A_RXC, rv); check("R2 rx count", rv, 32'h0);
      host_read(A_TXC, rv); check("R2 tx count", rv, 32'h0);
      host_read(A_INT, rv); check("R2 int", rv, 32'h0);
      // R1 identity
      host_read(A_IDL, rv); check("R1 id low", rv, 32'h4D544B50);
      host_read(A_IDH, rv); check("R1 id high", rv, 32'h31584F42);
      host_read(A_INF, rv); check("R1 info", rv, 32'h2);
      // R7 stray data write while idle
      tx_q.delete();
      host_write(A_TXD, 32'hAB);
      repeat (3) @(negedge clk);
      check("R7 idle write no output", 32'(tx_q.size()), 32'h0);
      host_read(A_TXC, rv); check("R7 idle write count", rv, 32'h0);
      // R10 test interrupt
      host_write(A_INT, 32'h8000_0000);
      check("R10 irq raised", 32'(irq), 32'h1);
      host_read(A_INT, rv); check("R10 first read", rv, 32'h8000_0000);
      host_read(A_INT, rv); check("R10 cleared on read", rv, 32'h0);
      check("R10 irq held", 32'(irq), 32'h1);
      host_write(A_INT, 32'h0);
      check("R10 released", 32'(irq), 32'h0);
      // R11 partial rx frame holds busy
      for (int i = 0; i < 5; i++) rx_bytes[i] = 8'($urandom);
      for (int i = 0; i < 3; i++) rx_beat(rx_bytes[i], 1'b0);
      @(negedge clk); rx_valid = 1'b0;
      host_read(A_BSY, rv); check("R11 busy rx", rv, 32'h1);
      rx_beat(rx_bytes[3], 1'b0); rx_beat(rx_bytes[4], 1'b1);
      @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
      host_read(A_BSY, rv); check("R11 rx done", rv, 32'h0);
      // R5 lockout, R9 partial clear
      host_write(A_INT, 32'h1);
      host_read(A_INT, rv); check("R9 bit1 kept", rv, 32'h2);
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'hEE; rx_last = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); check("R5 held off", 32'(rx_ready), 32'h0);
      end
      rx_valid = 1'b0; rx_last = 1'b0;
      rx_check(5);
      // R6 overlong rx, single byte, full depth
      for (int i = 0; i < DEPTH + 5; i++) rx_bytes[i] = 8'($urandom);
      rx_send(DEPTH + 5); rx_check(DEPTH + 5);
      rx_bytes[0] = 8'h5A; rx_send(1); rx_check(1);
      // R7 overlong tx, boundary lengths
      tx_run(DEPTH + 10);
      tx_run(1);
      // random traffic
      for (int k = 0; k < 6; k++) begin
         int n;
         n = 1 + int'($urandom % DEPTH);
         for (int i = 0; i < n; i++) rx_bytes[i] = 8'($urandom);
         rx_send(n); rx_check(n);
         tx_run(1 + int'($urandom % DEPTH));
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end
endmodule